// File: doc/BRIEF.md
# NAND Flash Bus-Operation Decoder

This block is the device-side front end of a small-page NAND memory model. It watches a multiplexed bus and its strobes: chip enable, command latch, address latch, read enable, write enable and write protect. All of these are synchronised to a system clock. Each rising edge of write enable is sorted into a command, address or data-input cycle by the levels of the other strobes. A command byte selects an operation. Address cycles are assembled into a column byte and a row (page) number. Data-input bytes are streamed to an external page buffer, and falling edges of read enable step a column counter through that buffer during data output.

The block drives a ready/busy output that is low while a modelled read, program or erase is in progress. Each busy period is a fixed, parameterised number of clock cycles. Program and erase are gated by the live level of write protect at the moment the command arrives. Chip enable rising during a read busy period aborts the read, unless the chip-enable-don't-care parameter is set. Chip enable rising during a program or erase busy period is ignored.

Page-buffer writes leave on a valid/ready stream (`pb_wvalid`, `pb_wready`). A byte is held with valid high until ready is seen high on a clock edge. The bus itself cannot stall, so ready must return before the next data-input cycle is decoded; a byte decoded while the previous one is still held replaces it.

Top module: `nand_bus_decoder`

## Requirements
- R1: A write-enable rising edge seen with chip enable low, command latch high, address latch low and read enable high is a command cycle: `cyc_type` becomes 1 and `cmd_byte` takes bus bits 7:0. A rising edge with chip enable high, with both latches high, or with read enable low sets `cyc_type` to 0 and leaves `cmd_byte` unchanged.
- R2: A write-enable rising edge with chip enable low, address latch high, command latch low and read enable high is an address cycle (`cyc_type` = 2). The first address cycle after a command sets `addr_col`; later cycles fill `addr_row`, least significant byte first.
- R3: A write-enable rising edge with chip enable low, both latches low and read enable high is a data cycle (`cyc_type` = 3). After a program command (0x80) and a complete address, each data cycle presents the full bus word on `pb_wdata` with `pb_wcol` starting at `addr_col` and rising by one per byte. `pb_wvalid` stays high until `pb_wready` is high.
- R4: With LARGE_DENSITY=1 an address takes four cycles (24-bit row); with LARGE_DENSITY=0 it takes three (16-bit row). Address cycles beyond that count leave `addr_col` and `addr_row` unchanged.
- R5: Command and address cycles use only bus bits 7:0; bits 15:8 have no effect on them.
- R6: A program command (0x80), program confirm (0x10), erase command (0x60) or erase confirm (0xD0) is refused while write protect is low at the time of that cycle: no start pulse, no busy period and no page-buffer write follow. Write protect is taken at its live level, not latched.
- R7: After a read address completes (command 0x00), after an accepted program confirm (`pgm_start` pulse) or after an accepted erase confirm (`ers_start` pulse), `rb` is low for exactly RD_BUSY, PG_BUSY or ER_BUSY clock cycles respectively, and high otherwise.
- R8: Chip enable going high during a program or erase busy period does not shorten that period.
- R9: Chip enable going high during a read busy period ends it at once, with `rb` high and the block in standby with data output off. With CE_DONT_CARE=1 the read runs its full busy period and then enters data output.
- R10: In data output after a read, each falling edge of read enable loads `dout` with the page-buffer word at the current column (`pb_raddr`) and then advances the column by one, starting from `addr_col`.
- R11: While `rb` is low, write-enable edges are not decoded: `cyc_type`, `cmd_byte` and the address are left unchanged.
- R12: `dout_oe` is high only in data output with chip enable low and both latches low; chip enable high turns it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| re_n | input | 1 | Read enable, active low |
| we_n | input | 1 | Write enable, active low; rising edge captures the bus |
| wp_n | input | 1 | Write protect, active low |
| din | input | BUS_W | Bus input word |
| dout | output | BUS_W | Bus output word |
| dout_oe | output | 1 | Bus output enable |
| rb | output | 1 | Ready (1) / busy (0) |
| cyc_type | output | 2 | Last decoded cycle: 0 none, 1 command, 2 address, 3 data |
| cmd_byte | output | 8 | Last accepted command byte |
| addr_col | output | 8 | Assembled column byte |
| addr_row | output | 8*(N_ADDR-1) | Assembled row number |
| pb_wvalid | output | 1 | Page-buffer write valid |
| pb_wready | input | 1 | Page-buffer write ready |
| pb_wdata | output | BUS_W | Page-buffer write word |
| pb_wcol | output | 8 | Page-buffer write column |
| pb_raddr | output | 8 | Page-buffer read column |
| pb_rdata | input | BUS_W | Page-buffer read word |
| pgm_start | output | 1 | One-cycle pulse: program accepted |
| ers_start | output | 1 | One-cycle pulse: erase accepted |

## Verification
The bench sends more address cycles than each density needs. A decoder that kept counting would overwrite the row or shift it, so the extra bytes are checked to leave it unchanged. It drops write protect between an erase command and its confirm, which a design that latched protect at the command would wrongly accept. It raises chip enable inside both a program busy period and a read busy period, so a block that treated the two alike either cuts the program short or fails to abort the read. It also holds page-buffer ready low on a data byte, where a design that ignored back-pressure would drop valid early. Busy lengths are counted to the exact cycle, and address and command cycles issued while busy must not disturb the decoded state.

// File: rtl/nand_bd_pkg.sv
package nand_bd_pkg;
  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_ADDR = 2'd2,
    CYC_DIN  = 2'd3
  } cyc_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RADDR,
    ST_RBUSY,
    ST_ROUT,
    ST_PADDR,
    ST_PDATA,
    ST_PBUSY,
    ST_EADDR,
    ST_EBUSY
  } state_e;

  localparam logic [7:0] CMD_READ     = 8'h00;
  localparam logic [7:0] CMD_PROG     = 8'h80;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
endpackage

// File: rtl/nand_bd_sync.sv
module nand_bd_sync #(
  parameter int         W   = 6,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST;
      q  <= RST;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/nand_bd_classify.sv
module nand_bd_classify
  import nand_bd_pkg::*;
(
  input  logic ce_n,
  input  logic cle,
  input  logic ale,
  input  logic re_n,
  output cyc_e cyc
);
  always_comb begin
    cyc = CYC_NONE;
    if (!ce_n && re_n) begin
      unique case ({cle, ale})
        2'b10:   cyc = CYC_CMD;
        2'b01:   cyc = CYC_ADDR;
        2'b00:   cyc = CYC_DIN;
        default: cyc = CYC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/nand_bd_addr.sv
module nand_bd_addr #(
  parameter int N_CYC = 4,
  localparam int ROW_W = 8 * (N_CYC - 1),
  localparam int CNT_W = $clog2(N_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [7:0]       byte_in,
  output logic [7:0]       col,
  output logic [ROW_W-1:0] row,
  output logic             first,
  output logic             last,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic [7:0]       byte_q [N_CYC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < N_CYC; i++) byte_q[i] <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (wr && (cnt < CNT_W'(N_CYC))) begin
      for (int i = 0; i < N_CYC; i++) begin
        if (cnt == CNT_W'(i)) byte_q[i] <= byte_in;
      end
      cnt <= cnt + 1'b1;
    end
  end

  assign col = byte_q[0];

  genvar g;
  generate
    for (g = 1; g < N_CYC; g++) begin : g_row
      assign row[(g-1)*8 +: 8] = byte_q[g];
    end
  endgenerate

  assign first = (cnt == '0);
  assign last  = (cnt == CNT_W'(N_CYC - 1));
  assign done  = (cnt == CNT_W'(N_CYC));
endmodule

// File: rtl/nand_bd_ctrl.sv
module nand_bd_ctrl
  import nand_bd_pkg::*;
#(
  parameter int BUS_W        = 16,
  parameter bit CE_DONT_CARE = 1'b0,
  parameter int RD_BUSY      = 20,
  parameter int PG_BUSY      = 60,
  parameter int ER_BUSY      = 50,
  localparam int MAX_B = (RD_BUSY > PG_BUSY) ?
                         ((RD_BUSY > ER_BUSY) ? RD_BUSY : ER_BUSY) :
                         ((PG_BUSY > ER_BUSY) ? PG_BUSY : ER_BUSY),
  localparam int BW = $clog2(MAX_B + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_rise,
  input  logic             re_fall,
  input  logic             ce_s,
  input  logic             cle_s,
  input  logic             ale_s,
  input  logic             wp_s,
  input  cyc_e             cyc,
  input  logic [BUS_W-1:0] din,
  input  logic             a_first,
  input  logic             a_last,
  input  logic             a_done,
  input  logic [7:0]       a_col,
  output logic             a_clr,
  output logic             a_wr,
  output logic             rb,
  output logic [BUS_W-1:0] dout,
  output logic             dout_oe,
  output logic [1:0]       cyc_type,
  output logic [7:0]       cmd_byte,
  output logic             pb_wvalid,
  input  logic             pb_wready,
  output logic [BUS_W-1:0] pb_wdata,
  output logic [7:0]       pb_wcol,
  output logic [7:0]       pb_raddr,
  input  logic [BUS_W-1:0] pb_rdata,
  output logic             pgm_start,
  output logic             ers_start
);
  state_e        st;
  cyc_e          cyc_q;
  logic [BW-1:0] bcnt;
  logic [7:0]    col;
  logic          busy, acc, cmd_acc, addr_acc, din_acc, in_prog;
  logic [7:0]    cmd_b;

  assign busy     = (st == ST_RBUSY) || (st == ST_PBUSY) || (st == ST_EBUSY);
  assign acc      = we_rise && !busy;
  assign cmd_acc  = acc && (cyc == CYC_CMD);
  assign addr_acc = acc && (cyc == CYC_ADDR);
  assign din_acc  = acc && (cyc == CYC_DIN);
  assign in_prog  = (st == ST_PADDR) || (st == ST_PDATA);
  assign cmd_b    = din[7:0];
  assign a_clr    = cmd_acc;
  assign a_wr     = addr_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cyc_q     <= CYC_NONE;
      cmd_byte  <= '0;
      bcnt      <= '0;
      col       <= '0;
      pb_wvalid <= 1'b0;
      pb_wdata  <= '0;
      pb_wcol   <= '0;
      dout      <= '0;
      pgm_start <= 1'b0;
      ers_start <= 1'b0;
    end else begin
      pgm_start <= 1'b0;
      ers_start <= 1'b0;
      if (pb_wvalid && pb_wready) pb_wvalid <= 1'b0;
      if (acc) cyc_q <= cyc;

      if (cmd_acc) begin
        cmd_byte <= cmd_b;
        case (cmd_b)
          CMD_READ:  st <= ST_RADDR;
          CMD_PROG:  st <= wp_s ? ST_PADDR : ST_IDLE;
          CMD_ERASE: st <= wp_s ? ST_EADDR : ST_IDLE;
          CMD_PROG_GO: begin
            if (in_prog && a_done && wp_s) begin
              st        <= ST_PBUSY;
              bcnt      <= BW'(PG_BUSY - 1);
              pgm_start <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
          CMD_ERASE_GO: begin
            if ((st == ST_EADDR) && a_done && wp_s) begin
              st        <= ST_EBUSY;
              bcnt      <= BW'(ER_BUSY - 1);
              ers_start <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end else if (addr_acc) begin
        if (a_first) col <= cmd_b;
        if ((st == ST_RADDR) && a_last) begin
          st   <= ST_RBUSY;
          bcnt <= BW'(RD_BUSY - 1);
        end
      end else if (din_acc && in_prog && a_done) begin
        st        <= ST_PDATA;
        pb_wvalid <= 1'b1;
        pb_wdata  <= din;
        pb_wcol   <= col;
        col       <= col + 1'b1;
      end else begin
        case (st)
          ST_RBUSY: begin
            if (ce_s && !CE_DONT_CARE) st <= ST_IDLE;
            else if (bcnt == '0)       st <= ST_ROUT;
            else                       bcnt <= bcnt - 1'b1;
          end
          ST_PBUSY, ST_EBUSY: begin
            if (bcnt == '0) st <= ST_IDLE;
            else            bcnt <= bcnt - 1'b1;
          end
          ST_ROUT: begin
            if (re_fall && !ce_s) begin
              dout <= pb_rdata;
              col  <= col + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rb       = !busy;
  assign dout_oe  = (st == ST_ROUT) && !ce_s && !cle_s && !ale_s;
  assign cyc_type = cyc_q;
  assign pb_raddr = col;
endmodule

// File: rtl/nand_bus_decoder.sv
module nand_bus_decoder
  import nand_bd_pkg::*;
#(
  parameter int BUS_W         = 16,
  parameter bit LARGE_DENSITY = 1'b1,
  parameter bit CE_DONT_CARE  = 1'b0,
  parameter int RD_BUSY       = 20,
  parameter int PG_BUSY       = 60,
  parameter int ER_BUSY       = 50,
  localparam int N_ADDR = LARGE_DENSITY ? 4 : 3,
  localparam int ROW_W  = 8 * (N_ADDR - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             re_n,
  input  logic             we_n,
  input  logic             wp_n,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout,
  output logic             dout_oe,
  output logic             rb,
  output logic [1:0]       cyc_type,
  output logic [7:0]       cmd_byte,
  output logic [7:0]       addr_col,
  output logic [ROW_W-1:0] addr_row,
  output logic             pb_wvalid,
  input  logic             pb_wready,
  output logic [BUS_W-1:0] pb_wdata,
  output logic [7:0]       pb_wcol,
  output logic [7:0]       pb_raddr,
  input  logic [BUS_W-1:0] pb_rdata,
  output logic             pgm_start,
  output logic             ers_start
);
  logic [5:0]       ctl_s;
  logic [BUS_W-1:0] din_s;
  logic             ce_s, cle_s, ale_s, re_s, we_s, wp_s;
  logic             we_p, re_p, we_rise, re_fall;
  cyc_e             cyc;
  logic             a_clr, a_wr, a_first, a_last, a_done;

  nand_bd_sync #(.W(6), .RST(6'b111001)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({wp_n, we_n, re_n, ale, cle, ce_n}),
    .q(ctl_s)
  );

  nand_bd_sync #(.W(BUS_W), .RST('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
  );

  assign {wp_s, we_s, re_s, ale_s, cle_s, ce_s} = ctl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_p <= 1'b1;
      re_p <= 1'b1;
    end else begin
      we_p <= we_s;
      re_p <= re_s;
    end
  end

  assign we_rise = we_s && !we_p;
  assign re_fall = !re_s && re_p;

  nand_bd_classify u_cls (
    .ce_n(ce_s), .cle(cle_s), .ale(ale_s), .re_n(re_s), .cyc(cyc)
  );

  nand_bd_addr #(.N_CYC(N_ADDR)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(a_clr), .wr(a_wr),
    .byte_in(din_s[7:0]), .col(addr_col), .row(addr_row),
    .first(a_first), .last(a_last), .done(a_done)
  );

  nand_bd_ctrl #(
    .BUS_W(BUS_W), .CE_DONT_CARE(CE_DONT_CARE),
    .RD_BUSY(RD_BUSY), .PG_BUSY(PG_BUSY), .ER_BUSY(ER_BUSY)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_rise(we_rise), .re_fall(re_fall),
    .ce_s(ce_s), .cle_s(cle_s), .ale_s(ale_s), .wp_s(wp_s),
    .cyc(cyc), .din(din_s),
    .a_first(a_first), .a_last(a_last), .a_done(a_done), .a_col(addr_col),
    .a_clr(a_clr), .a_wr(a_wr),
    .rb(rb), .dout(dout), .dout_oe(dout_oe),
    .cyc_type(cyc_type), .cmd_byte(cmd_byte),
    .pb_wvalid(pb_wvalid), .pb_wready(pb_wready), .pb_wdata(pb_wdata),
    .pb_wcol(pb_wcol), .pb_raddr(pb_raddr), .pb_rdata(pb_rdata),
    .pgm_start(pgm_start), .ers_start(ers_start)
  );
endmodule

// File: rtl/nand_bus_decoder_chk.sv
module nand_bus_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rb,
  input logic       pgm_start,
  input logic       ers_start,
  input logic       wp_s,
  input logic       pb_wvalid,
  input logic       pb_wready,
  input logic [7:0] cmd_byte,
  input logic       a_done,
  input logic       a_clr
);
  assert_pgm_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> !rb);

  assert_ers_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ers_start |-> !rb);

  assert_pgm_wp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> $past(wp_s));

  assert_ers_wp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ers_start |-> $past(wp_s));

  assert_wvalid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_wvalid && !pb_wready) |=> pb_wvalid);

  assert_busy_no_decode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rb |=> $stable(cmd_byte));

  assert_addr_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_done && !a_clr) |=> a_done);
endmodule

bind nand_bus_decoder nand_bus_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rb(rb), .pgm_start(pgm_start),
  .ers_start(ers_start), .wp_s(wp_s), .pb_wvalid(pb_wvalid),
  .pb_wready(pb_wready), .cmd_byte(cmd_byte), .a_done(a_done), .a_clr(a_clr)
);

// File: tb/nand_bus_decoder_tb.sv
`timescale 1ns/1ps
module nand_bus_decoder_tb;
  localparam int RD = 20, PG = 60, ER = 50;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, cle = 0, ale = 0, re_n = 1, we_n = 1, wp_n = 1;
  logic [15:0] din = '0;
  logic pb_wready = 1;

  logic [15:0] dout, pb_wdata, pb_rdata;
  logic dout_oe, rb, pb_wvalid, pgm_start, ers_start;
  logic [1:0] cyc_type;
  logic [7:0] cmd_byte, addr_col, pb_wcol, pb_raddr;
  logic [23:0] addr_row;

  logic [15:0] dout_d, wdata_d, rdata_d;
  logic oe_d, rb_d, wvalid_d, pgm_d, ers_d;
  logic [1:0] cyc_d;
  logic [7:0] cmd_d, col_d, wcol_d, raddr_d;
  logic [15:0] row_d;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] pat(input logic [7:0] a);
    return {a ^ 8'hA5, a};
  endfunction

  assign pb_rdata = pat(pb_raddr);
  assign rdata_d  = pat(raddr_d);

  nand_bus_decoder #(.BUS_W(16), .LARGE_DENSITY(1), .CE_DONT_CARE(0),
    .RD_BUSY(RD), .PG_BUSY(PG), .ER_BUSY(ER)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .re_n(re_n),
    .we_n(we_n), .wp_n(wp_n), .din(din), .dout(dout), .dout_oe(dout_oe),
    .rb(rb), .cyc_type(cyc_type), .cmd_byte(cmd_byte), .addr_col(addr_col),
    .addr_row(addr_row), .pb_wvalid(pb_wvalid), .pb_wready(pb_wready),
    .pb_wdata(pb_wdata), .pb_wcol(pb_wcol), .pb_raddr(pb_raddr),
    .pb_rdata(pb_rdata), .pgm_start(pgm_start), .ers_start(ers_start));

  nand_bus_decoder #(.BUS_W(16), .LARGE_DENSITY(0), .CE_DONT_CARE(1),
    .RD_BUSY(RD), .PG_BUSY(PG), .ER_BUSY(ER)) u_dut_dc (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .re_n(re_n),
    .we_n(we_n), .wp_n(wp_n), .din(din), .dout(dout_d), .dout_oe(oe_d),
    .rb(rb_d), .cyc_type(cyc_d), .cmd_byte(cmd_d), .addr_col(col_d),
    .addr_row(row_d), .pb_wvalid(wvalid_d), .pb_wready(pb_wready),
    .pb_wdata(wdata_d), .pb_wcol(wcol_d), .pb_raddr(raddr_d),
    .pb_rdata(rdata_d), .pgm_start(pgm_d), .ers_start(ers_d));

  // monitors
  int run = 0, last_run = 0, low_tot = 0;
  int run_d = 0, last_run_d = 0;
  int pgm_cnt = 0, ers_cnt = 0, wr_cnt = 0;
  logic [15:0] wr_data [8];
  logic [7:0]  wr_col  [8];

  always @(negedge clk) if (rst_n) begin
    if (!rb) begin run++; low_tot++; end
    else if (run != 0) begin last_run = run; run = 0; end
    if (!rb_d) run_d++;
    else if (run_d != 0) begin last_run_d = run_d; run_d = 0; end
    if (pgm_start) pgm_cnt++;
    if (ers_start) ers_cnt++;
    if (pb_wvalid && pb_wready) begin
      if (wr_cnt < 8) begin wr_data[wr_cnt] = pb_wdata; wr_col[wr_cnt] = pb_wcol; end
      wr_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("[TB] FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus(input logic c_cle, input logic c_ale, input logic c_re, input logic [15:0] d);
    @(negedge clk);
    cle = c_cle; ale = c_ale; re_n = c_re; din = d;
    clks(2); we_n = 0; clks(3); we_n = 1; clks(4);
    cle = 0; ale = 0; re_n = 1;
  endtask

  task automatic cmd(input logic [15:0] d);  bus(1, 0, 1, d); endtask
  task automatic adr(input logic [15:0] d);  bus(0, 1, 1, d); endtask
  task automatic dat(input logic [15:0] d);  bus(0, 0, 1, d); endtask

  task automatic t_reset;
    check(rb == 1, "R7 reset ready", rb, 1);
    check(dout_oe == 0, "R12 reset oe", dout_oe, 0);
    check(cyc_type == 0, "R1 reset cyc", cyc_type, 0);
    check(pb_wvalid == 0, "R3 reset wvalid", pb_wvalid, 0);
  endtask

  task automatic t_cycles;
    ce_n = 0;
    cmd(16'h00FF);
    check(cyc_type == 1, "R1 cmd type", cyc_type, 1);
    check(cmd_byte == 8'hFF, "R1 cmd byte", cmd_byte, 8'hFF);
    adr(16'h0033);
    check(cyc_type == 2, "R2 addr type", cyc_type, 2);
    check(addr_col == 8'h33, "R2 first addr is col", addr_col, 8'h33);
    dat(16'h1111);
    check(cyc_type == 3, "R3 data type", cyc_type, 3);
    bus(1, 1, 1, 16'h0055);
    check(cyc_type == 0, "R1 both latches", cyc_type, 0);
    bus(1, 0, 0, 16'h0055);
    check(cyc_type == 0, "R1 re low", cyc_type, 0);
    ce_n = 1;
    cmd(16'h0055);
    check(cyc_type == 0, "R1 ce high type", cyc_type, 0);
    check(cmd_byte == 8'hFF, "R1 ce high keeps cmd", cmd_byte, 8'hFF);
    ce_n = 0;
    check(wr_cnt == 0, "R3 no write outside program", wr_cnt, 0);
  endtask

  task automatic t_program;
    int p0;
    p0 = pgm_cnt;
    ce_n = 0; wp_n = 1;
    cmd(16'hAB80);
    check(cmd_byte == 8'h80, "R5 cmd low byte", cmd_byte, 8'h80);
    adr(16'hEE04); adr(16'h0011); adr(16'h0022); adr(16'h0033); adr(16'h0044);
    check(addr_col == 8'h04, "R5 col low byte", addr_col, 8'h04);
    check(addr_row == 24'h332211, "R4 four-cycle row, extra ignored", addr_row, 24'h332211);
    check(row_d == 16'h2211, "R4 three-cycle row, extras ignored", row_d, 16'h2211);
    dat(16'h1234); dat(16'h5678);
    check(wr_cnt == 2, "R3 write count", wr_cnt, 2);
    check(wr_data[0] == 16'h1234 && wr_col[0] == 8'h04, "R3 first write",
          {wr_data[0], wr_col[0]}, {16'h1234, 8'h04});
    check(wr_data[1] == 16'h5678 && wr_col[1] == 8'h05, "R3 second write",
          {wr_data[1], wr_col[1]}, {16'h5678, 8'h05});
    pb_wready = 0;
    dat(16'h9ABC);
    clks(10);
    check(pb_wvalid == 1, "R3 valid held without ready", pb_wvalid, 1);
    pb_wready = 1;
    clks(3);
    check(pb_wvalid == 0, "R3 valid drops after ready", pb_wvalid, 0);
    check(wr_cnt == 3 && wr_data[2] == 16'h9ABC && wr_col[2] == 8'h06, "R3 held write",
          {wr_data[2], wr_col[2]}, {16'h9ABC, 8'h06});
    cmd(16'h0010);
    check(pgm_cnt == p0 + 1, "R7 program start", pgm_cnt, p0 + 1);
    check(rb == 0, "R7 busy after confirm", rb, 0);
    adr(16'h0099);
    check(addr_row == 24'h332211, "R11 addr ignored while busy", addr_row, 24'h332211);
    check(cyc_type == 1, "R11 cyc kept while busy", cyc_type, 1);
    ce_n = 1; clks(10); ce_n = 0;
    clks(PG + 10);
    check(last_run == PG, "R8 program busy length with ce high", last_run, PG);
    check(last_run_d == PG, "R7 program busy length", last_run_d, PG);
  endtask

  task automatic t_read;
    ce_n = 0;
    cmd(16'h0000);
    adr(16'h0020); adr(16'h0001); adr(16'h0002); adr(16'h0003);
    clks(RD + 15);
    check(last_run == RD, "R7 read busy length", last_run, RD);
    check(last_run_d == RD, "R7 read busy length 3-cycle", last_run_d, RD);
    check(addr_row == 24'h030201, "R2 row byte order", addr_row, 24'h030201);
    check(dout_oe == 1, "R12 oe in data output", dout_oe, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); re_n = 0; clks(4);
      check(dout == pat(8'h20 + 8'(k)), "R10 read word", dout, pat(8'h20 + 8'(k)));
      re_n = 1; clks(3);
    end
    check(pb_raddr == 8'h23, "R10 column advanced", pb_raddr, 8'h23);
    ce_n = 1; clks(5);
    check(dout_oe == 0, "R12 oe off with ce high", dout_oe, 0);
    ce_n = 0; clks(5);
    check(dout_oe == 1, "R12 oe back with ce low", dout_oe, 1);
  endtask

  task automatic t_abort;
    ce_n = 0;
    cmd(16'h0000);
    adr(16'h0040); adr(16'h0005); adr(16'h0006); adr(16'h0007);
    clks(2);
    ce_n = 1; clks(6); ce_n = 0;
    clks(RD + 10);
    check(last_run < RD && last_run > 0, "R9 read aborted early", last_run, RD);
    check(dout_oe == 0, "R9 standby after abort", dout_oe, 0);
    check(last_run_d == RD, "R9 ce-dont-care full busy", last_run_d, RD);
    check(oe_d == 1, "R9 ce-dont-care enters data output", oe_d, 1);
    check(row_d == 16'h0605, "R11 addr ignored while read busy", row_d, 16'h0605);
  endtask

  task automatic t_protect;
    int w0, l0, p0, e0;
    w0 = wr_cnt; l0 = low_tot; p0 = pgm_cnt; e0 = ers_cnt;
    ce_n = 0; wp_n = 0;
    cmd(16'h0080);
    adr(16'h0000); adr(16'h0001); adr(16'h0002); adr(16'h0003);
    dat(16'hDEAD);
    cmd(16'h0010);
    clks(PG + 5);
    check(wr_cnt == w0, "R6 no write when protected", wr_cnt, w0);
    check(pgm_cnt == p0, "R6 program refused", pgm_cnt, p0);
    check(low_tot == l0, "R6 no busy when protected", low_tot, l0);
    wp_n = 1;
    cmd(16'h0060);
    adr(16'h0000); adr(16'h0008); adr(16'h0009); adr(16'h000A);
    wp_n = 0;
    cmd(16'h00D0);
    clks(ER + 5);
    check(ers_cnt == e0, "R6 erase refused, live protect", ers_cnt, e0);
    check(low_tot == l0, "R6 no erase busy", low_tot, l0);
    wp_n = 1;
    cmd(16'h0060);
    adr(16'h0000); adr(16'h0008); adr(16'h0009); adr(16'h000A);
    cmd(16'h00D0);
    check(ers_cnt == e0 + 1, "R6 erase accepted", ers_cnt, e0 + 1);
    clks(ER + 10);
    check(last_run == ER, "R7 erase busy length", last_run, ER);
  endtask

  initial begin
    clks(3);
    rst_n = 1;
    clks(3);
    t_reset;
    t_cycles;
    t_program;
    t_read;
    t_abort;
    t_protect;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(100000 * 20);
    tests++; fails++;
    $display("[TB] FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule